// File: doc/BRIEF.md
# Trim Calibration Sequencer for a Two-Resistor Amplifier Channel

This block runs the power-on calibration of one amplifier channel whose gain network holds two digitally trimmed resistors, one that sets the gain and one that balances the common-mode rejection. The block starts on its own once after reset. It steers the channel's input switches, steps each trim code through its full range, and measures the channel's digitised output for every code. From those measurements it keeps the best setting for each resistor.

The calibration has two phases, always in the same order. In the gain phase the stimulus reaches input B while input A is tied to the reference. Every gain code is tried, and the block keeps the code whose output energy lies nearest a programmed target. In the common-mode phase the two inputs are tied together, so the stimulus appears as a common-mode signal. The gain code stays at its chosen value, every CMRR code is tried, and the block keeps the code with the least output energy. At the end both chosen codes are presented, the switches open, and a pass flag reports whether both residuals fall within programmed limits.

Each measurement is the sum of squared samples over fifty stimulus periods. The period length is given in samples. Energies are compared directly and no root is taken. After every change of code, a programmable number of samples is thrown away so the analog path can settle.

Top module: `trimCalSeq`

## Requirements
- R1: After reset is released the sequence starts by itself and runs exactly once. `calDone` stays low until both sweeps are finished, then stays high until the next reset, and no further sweep begins.
- R2: Gain phase: `routeStim`=1, `routeARef`=1 and `routeAB`=0. `gainTrim` steps through the codes 0,1,...,15 in ascending order, one step per measurement, and `cmTrim` stays 0.
- R3: Common-mode phase: `routeStim`=1, `routeAB`=1 and `routeARef`=0. `gainTrim` holds the code chosen in the gain phase for the whole phase, and `cmTrim` steps through 0..15 in ascending order.
- R4: After every change of trim code or routing, the first `settleCount` samples with `sampleValid`=1 are discarded and contribute nothing to the measurement. A value of 0 discards none.
- R5: The energy for a code is the sum of `sampleIn`² (signed) over the next 50×P valid samples, where P is `samplesPerPeriod` and a value of 0 counts as 1. Samples presented while `sampleValid`=0 are ignored.
- R6: The gain phase chooses the code that minimises |energy − `targetEnergy`|. On a tie the lower code wins.
- R7: The common-mode phase chooses the code with the smallest energy. On a tie the lower code wins.
- R8: While `calDone`=1, `gainTrim` and `cmTrim` show the two chosen codes, all three routing outputs are 0, and the outputs do not change.
- R9: `calPass`=1 exactly when `calDone`=1, the best gain error is ≤ `gainErrLimit`, and the best common-mode energy is ≤ `cmEnergyLimit`. Each comparison includes equality.
- R10: While reset is held, `calDone`, `calPass`, all routing outputs and both trim codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; calibration starts after its release |
| sampleIn | input | SAMPLE_W | Signed channel output sample |
| sampleValid | input | 1 | Qualifies `sampleIn` |
| samplesPerPeriod | input | SPP_W | Samples per stimulus period (0 is treated as 1) |
| settleCount | input | SETTLE_W | Valid samples discarded after each code change |
| targetEnergy | input | ACC_W | Desired energy for the gain phase |
| gainErrLimit | input | ACC_W | Largest acceptable gain energy error |
| cmEnergyLimit | input | ACC_W | Largest acceptable common-mode energy |
| routeStim | output | 1 | Connect stimulus to input B |
| routeARef | output | 1 | Tie input A to the reference |
| routeAB | output | 1 | Tie input A to input B |
| gainTrim | output | CODE_W | Gain trim code |
| cmTrim | output | CODE_W | CMRR trim code |
| calDone | output | 1 | Calibration finished |
| calPass | output | 1 | Both residuals within limits |

## Verification
The bench uses the default widths: 16-bit samples, 4-bit codes and fifty periods per window. It runs the block with period lengths of 0 to 3 samples and settle counts of 0 to 5. These short windows keep every run cheap while still covering all 32 measurements in each one, including the case where a period length of 0 is treated as 1 and the case where settling is skipped. The channel model sends large values in exactly the discarded slots and during invalid cycles, so any leak of those samples into a measurement changes the chosen code. The targets and limits are set to produce exact ties in both phases and pass/fail results exactly at the limit.

// File: rtl/trimcal_pkg.sv
package trimcal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SETTLE,
    ST_ACCUM,
    ST_EVAL,
    ST_DONE
  } calState_t;

  // strobes from sequencing control to the measurement datapath
  typedef struct packed {
    logic clearAcc;
    logic accumEn;
    logic evalEn;
    logic phaseCm;
    logic firstCode;
  } dpCtrl_t;

endpackage

// File: rtl/trimcal_best.sv
// Keeps the code with the smallest metric seen in one sweep; ties keep the earlier code.
module trimcal_best #(
  parameter int CODE_W = 4,
  parameter int MET_W  = 46
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evalEn,
  input  logic              firstCode,
  input  logic [CODE_W-1:0] code,
  input  logic [MET_W-1:0]  metric,
  output logic [CODE_W-1:0] bestCode,
  output logic [MET_W-1:0]  bestMetric
);

  logic takeIt;
  assign takeIt = evalEn && (firstCode || (metric < bestMetric));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestCode   <= '0;
      bestMetric <= '0;
    end else if (takeIt) begin
      bestCode   <= code;
      bestMetric <= metric;
    end
  end

endmodule

// File: rtl/trimcal_dp.sv
module trimcal_dp
  import trimcal_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 4,
  parameter int ACC_W    = 46
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dpCtrl_t                    dpCtl,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic [CODE_W-1:0]          sweepCode,
  input  logic [ACC_W-1:0]           targetEnergy,
  input  logic [ACC_W-1:0]           gainErrLimit,
  input  logic [ACC_W-1:0]           cmEnergyLimit,
  input  logic                       calDone,
  output logic [CODE_W-1:0]          bestGainCode,
  output logic [CODE_W-1:0]          bestCmCode,
  output logic                       calPass
);

  localparam int NUM_PHASES = 2;
  localparam int SQ_W       = 2 * SAMPLE_W;

  logic [ACC_W-1:0]        acc;
  logic signed [SQ_W-1:0]  sq;
  logic [ACC_W-1:0]        gainErr;
  logic [ACC_W-1:0]        metric     [NUM_PHASES];
  logic [CODE_W-1:0]       bestCodeP  [NUM_PHASES];
  logic [ACC_W-1:0]        bestMetP   [NUM_PHASES];

  assign sq = sampleIn * sampleIn;

  // energy accumulator
  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (dpCtl.clearAcc) begin
      acc <= '0;
    end else if (dpCtl.accumEn) begin
      acc <= acc + ACC_W'($unsigned(sq));
    end
  end

  // distance of the measured energy from the target
  assign gainErr = (acc >= targetEnergy) ? (acc - targetEnergy) : (targetEnergy - acc);

  assign metric[0] = gainErr;   // gain phase: closeness to target
  assign metric[1] = acc;       // common-mode phase: raw energy

  for (genvar p = 0; p < NUM_PHASES; p++) begin : gPhase
    trimcal_best #(
      .CODE_W (CODE_W),
      .MET_W  (ACC_W)
    ) best_i (
      .clk        (clk),
      .rstN       (rstN),
      .evalEn     (dpCtl.evalEn && (dpCtl.phaseCm == 1'(p))),
      .firstCode  (dpCtl.firstCode),
      .code       (sweepCode),
      .metric     (metric[p]),
      .bestCode   (bestCodeP[p]),
      .bestMetric (bestMetP[p])
    );
  end

  assign bestGainCode = bestCodeP[0];
  assign bestCmCode   = bestCodeP[1];
  assign calPass      = calDone && (bestMetP[0] <= gainErrLimit) && (bestMetP[1] <= cmEnergyLimit);

endmodule

// File: rtl/trimcal_ctrl.sv
module trimcal_ctrl
  import trimcal_pkg::*;
#(
  parameter int CODE_W   = 4,
  parameter int SPP_W    = 8,
  parameter int SETTLE_W = 8,
  parameter int PERIODS  = 50,
  parameter int WIN_W    = 14
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SPP_W-1:0]    samplesPerPeriod,
  input  logic [SETTLE_W-1:0] settleCount,
  input  logic [CODE_W-1:0]   bestGainCode,
  input  logic [CODE_W-1:0]   bestCmCode,
  output dpCtrl_t             dpCtl,
  output logic [CODE_W-1:0]   sweepCode,
  output logic [CODE_W-1:0]   gainTrim,
  output logic [CODE_W-1:0]   cmTrim,
  output logic                routeStim,
  output logic                routeARef,
  output logic                routeAB,
  output logic                calDone
);

  localparam int CNT_W = (WIN_W > SETTLE_W) ? WIN_W : SETTLE_W;
  localparam logic [CODE_W-1:0] LAST_CODE = '1;

  calState_t         state, stateNxt;
  logic              phaseCm, phaseNxt;
  logic [CODE_W-1:0] code, codeNxt;
  logic [CNT_W-1:0]  cnt, cntNxt;
  logic [SPP_W-1:0]  sppEff;
  logic [CNT_W-1:0]  winLen;
  logic [CNT_W-1:0]  settleLen;
  calState_t         afterChange;
  logic              active;

  assign sppEff      = (samplesPerPeriod == '0) ? SPP_W'(1) : samplesPerPeriod;
  assign winLen      = CNT_W'(PERIODS) * CNT_W'(sppEff);
  assign settleLen   = CNT_W'(settleCount);
  assign afterChange = (settleLen == '0) ? ST_ACCUM : ST_SETTLE;

  always_comb begin
    stateNxt        = state;
    phaseNxt        = phaseCm;
    codeNxt         = code;
    cntNxt          = cnt;
    dpCtl           = '0;
    dpCtl.phaseCm   = phaseCm;
    dpCtl.firstCode = (code == '0);
    unique case (state)
      ST_IDLE: stateNxt = ST_START;
      ST_START: begin
        dpCtl.clearAcc = 1'b1;
        cntNxt         = '0;
        stateNxt       = afterChange;
      end
      ST_SETTLE: begin
        if (sampleValid) begin
          if (cnt == settleLen - 1'b1) begin
            cntNxt   = '0;
            stateNxt = ST_ACCUM;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
      end
      ST_ACCUM: begin
        if (sampleValid) begin
          dpCtl.accumEn = 1'b1;
          if (cnt == winLen - 1'b1) begin
            cntNxt   = '0;
            stateNxt = ST_EVAL;
          end else begin
            cntNxt = cnt + 1'b1;
          end
        end
      end
      ST_EVAL: begin
        dpCtl.evalEn   = 1'b1;
        dpCtl.clearAcc = 1'b1;
        if (code == LAST_CODE) begin
          codeNxt = '0;
          if (phaseCm) begin
            stateNxt = ST_DONE;
          end else begin
            phaseNxt = 1'b1;
            stateNxt = afterChange;
          end
        end else begin
          codeNxt  = code + 1'b1;
          stateNxt = afterChange;
        end
      end
      ST_DONE: stateNxt = ST_DONE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phaseCm <= 1'b0;
      code    <= '0;
      cnt     <= '0;
    end else begin
      state   <= stateNxt;
      phaseCm <= phaseNxt;
      code    <= codeNxt;
      cnt     <= cntNxt;
    end
  end

  assign active    = (state == ST_START) || (state == ST_SETTLE) ||
                     (state == ST_ACCUM) || (state == ST_EVAL);
  assign routeStim = active;
  assign routeARef = active && !phaseCm;
  assign routeAB   = active && phaseCm;
  assign calDone   = (state == ST_DONE);
  assign sweepCode = code;
  assign gainTrim  = phaseCm ? bestGainCode : code;
  assign cmTrim    = calDone ? bestCmCode : (phaseCm ? code : '0);

endmodule

// File: rtl/trimCalSeq.sv
module trimCalSeq
  import trimcal_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int CODE_W   = 4,
  parameter int SPP_W    = 8,
  parameter int SETTLE_W = 8,
  parameter int PERIODS  = 50,
  // derived from the parameters above; keep at its default
  parameter int ACC_W    = 2 * SAMPLE_W + $clog2(PERIODS * ((1 << SPP_W) - 1) + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic                       sampleValid,
  input  logic [SPP_W-1:0]           samplesPerPeriod,
  input  logic [SETTLE_W-1:0]        settleCount,
  input  logic [ACC_W-1:0]           targetEnergy,
  input  logic [ACC_W-1:0]           gainErrLimit,
  input  logic [ACC_W-1:0]           cmEnergyLimit,
  output logic                       routeStim,
  output logic                       routeARef,
  output logic                       routeAB,
  output logic [CODE_W-1:0]          gainTrim,
  output logic [CODE_W-1:0]          cmTrim,
  output logic                       calDone,
  output logic                       calPass
);

  localparam int WIN_W = $clog2(PERIODS * ((1 << SPP_W) - 1) + 1);

  dpCtrl_t           dpCtl;
  logic [CODE_W-1:0] sweepCode;
  logic [CODE_W-1:0] bestGainCode;
  logic [CODE_W-1:0] bestCmCode;

  trimcal_ctrl #(
    .CODE_W   (CODE_W),
    .SPP_W    (SPP_W),
    .SETTLE_W (SETTLE_W),
    .PERIODS  (PERIODS),
    .WIN_W    (WIN_W)
  ) ctrl_i (
    .clk              (clk),
    .rstN             (rstN),
    .sampleValid      (sampleValid),
    .samplesPerPeriod (samplesPerPeriod),
    .settleCount      (settleCount),
    .bestGainCode     (bestGainCode),
    .bestCmCode       (bestCmCode),
    .dpCtl            (dpCtl),
    .sweepCode        (sweepCode),
    .gainTrim         (gainTrim),
    .cmTrim           (cmTrim),
    .routeStim        (routeStim),
    .routeARef        (routeARef),
    .routeAB          (routeAB),
    .calDone          (calDone)
  );

  trimcal_dp #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W),
    .ACC_W    (ACC_W)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .dpCtl         (dpCtl),
    .sampleIn      (sampleIn),
    .sweepCode     (sweepCode),
    .targetEnergy  (targetEnergy),
    .gainErrLimit  (gainErrLimit),
    .cmEnergyLimit (cmEnergyLimit),
    .calDone       (calDone),
    .bestGainCode  (bestGainCode),
    .bestCmCode    (bestCmCode),
    .calPass       (calPass)
  );

endmodule

// File: rtl/trimcal_chk.sv
module trimcal_chk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              routeStim,
  input logic              routeARef,
  input logic              routeAB,
  input logic [CODE_W-1:0] gainTrim,
  input logic [CODE_W-1:0] cmTrim,
  input logic              calDone,
  input logic              calPass
);

  // R2: gain-phase switch pattern
  a_r2_gain_routing: assert property (@(posedge clk) disable iff (!rstN)
    routeARef |-> (routeStim && !routeAB));

  // R2: gain codes only advance by one inside the gain phase
  a_r2_code_step: assert property (@(posedge clk) disable iff (!rstN)
    (routeARef && $past(routeARef) && (gainTrim != $past(gainTrim)))
      |-> (gainTrim == $past(gainTrim) + 1'b1));

  // R3: common-mode switch pattern
  a_r3_cm_routing: assert property (@(posedge clk) disable iff (!rstN)
    routeAB |-> (routeStim && !routeARef));

  // R3: gain code frozen through the common-mode sweep
  a_r3_gain_held: assert property (@(posedge clk) disable iff (!rstN)
    (routeAB && $past(routeAB)) |-> $stable(gainTrim));

  // R1: completion is sticky until reset
  a_r1_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    calDone |=> calDone);

  // R8: switches open once finished
  a_r8_routes_off: assert property (@(posedge clk) disable iff (!rstN)
    calDone |-> (!routeStim && !routeARef && !routeAB));

  // R8: results frozen once finished
  a_r8_codes_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && $past(calDone)) |-> ($stable(gainTrim) && $stable(cmTrim)));

  // R9: pass only reported with completion
  a_r9_pass_needs_done: assert property (@(posedge clk) disable iff (!rstN)
    calPass |-> calDone);

endmodule

bind trimCalSeq trimcal_chk #(.CODE_W(CODE_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .routeStim (routeStim),
  .routeARef (routeARef),
  .routeAB   (routeAB),
  .gainTrim  (gainTrim),
  .cmTrim    (cmTrim),
  .calDone   (calDone),
  .calPass   (calPass)
);

// File: tb/trimCalSeq_tb_top.sv
module trimCalSeq_tb_top;

  localparam int SAMPLE_W = 16;
  localparam int CODE_W   = 4;
  localparam int SPP_W    = 8;
  localparam int SETTLE_W = 8;
  localparam int PERIODS  = 50;
  localparam int ACC_W    = 2 * SAMPLE_W + $clog2(PERIODS * ((1 << SPP_W) - 1) + 1);
  localparam int JUNK     = 30000;
  localparam int CASE_LIMIT = 30000;

  logic                       clk = 1'b0;
  logic                       rstN = 1'b0;
  logic signed [SAMPLE_W-1:0] sampleIn;
  logic                       sampleValid;
  logic [SPP_W-1:0]           samplesPerPeriod;
  logic [SETTLE_W-1:0]        settleCount;
  logic [ACC_W-1:0]           targetEnergy;
  logic [ACC_W-1:0]           gainErrLimit;
  logic [ACC_W-1:0]           cmEnergyLimit;
  logic                       routeStim, routeARef, routeAB;
  logic [CODE_W-1:0]          gainTrim, cmTrim;
  logic                       calDone, calPass;

  always #5 clk = ~clk;

  trimCalSeq dut_i (
    .clk              (clk),
    .rstN             (rstN),
    .sampleIn         (sampleIn),
    .sampleValid      (sampleValid),
    .samplesPerPeriod (samplesPerPeriod),
    .settleCount      (settleCount),
    .targetEnergy     (targetEnergy),
    .gainErrLimit     (gainErrLimit),
    .cmEnergyLimit    (cmEnergyLimit),
    .routeStim        (routeStim),
    .routeARef        (routeARef),
    .routeAB          (routeAB),
    .gainTrim         (gainTrim),
    .cmTrim           (cmTrim),
    .calDone          (calDone),
    .calPass          (calPass)
  );

  typedef struct {
    int gain;
    int cm;
    bit pass;
  } expItem_t;

  expItem_t expQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int cfgSettle = 0;
  int cfgPcm    = 0;
  bit cfgGaps   = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // channel model: amplitude seen for a gain code / CMRR code
  function automatic int gAmp(input int c);
    return 100 + 10 * c;
  endfunction

  function automatic int cAmp(input int c);
    int d;
    d = 2 * c - cfgPcm;
    if (d < 0) d = -d;
    return 5 + 10 * d;
  endfunction

  // channel model driver: junk in discarded slots and on invalid cycles (R4, R5)
  initial begin : stimGen
    logic [10:0] cfg;
    logic [10:0] prevCfg;
    int k;
    int cyc;
    int amp;
    bit neg;
    prevCfg = '0; k = 0; cyc = 0; neg = 1'b0;
    sampleValid = 1'b0;
    sampleIn = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rstN) begin
        prevCfg = '0; k = 0;
        sampleValid = 1'b0;
        sampleIn = '0;
      end else begin
        cfg = {routeStim, routeARef, routeAB, gainTrim, cmTrim};
        if (cfg != prevCfg) k = 0;
        prevCfg = cfg;
        sampleValid = !(cfgGaps && (cyc % 3 == 2));
        if (sampleValid) begin
          if (k < cfgSettle) amp = JUNK;
          else if (routeAB) amp = cAmp(int'(cmTrim));
          else if (routeARef) amp = gAmp(int'(gainTrim));
          else amp = 0;
          sampleIn = neg ? SAMPLE_W'(-amp) : SAMPLE_W'(amp);
          neg = !neg;
          k++;
        end else begin
          sampleIn = SAMPLE_W'(-JUNK);
        end
      end
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    bit prevARef, prevAB, prevDone;
    logic [CODE_W-1:0] prevG, prevC;
    int gainSteps, cmSteps;
    int expGain;
    expItem_t item;
    prevARef = 0; prevAB = 0; prevDone = 0; prevG = '0; prevC = '0;
    gainSteps = 0; cmSteps = 0;
    forever begin
      @(negedge clk);
      if (!rstN) begin
        prevARef = 0; prevAB = 0; prevDone = 0; gainSteps = 0; cmSteps = 0;
      end else begin
        expGain = (expQ.size() > 0) ? expQ[0].gain : -1;
        if (routeARef && !prevARef) begin
          check(routeStim && !routeAB, "R2", "gain routing", {routeStim, routeAB}, 2'b10);
          check(gainTrim == 0 && cmTrim == 0, "R2", "first gain code", gainTrim, 0);
          gainSteps = 1;
        end else if (routeARef && gainTrim != prevG) begin
          check(gainTrim == prevG + 1'b1, "R2", "gain code step", gainTrim, prevG + 1);
          gainSteps++;
        end
        if (routeAB && !prevAB) begin
          check(gainSteps == 16, "R2", "gain codes visited", gainSteps, 16);
          check(int'(gainTrim) == expGain, "R3", "gain code held at cm start", gainTrim, expGain);
          check(!routeARef && routeStim && cmTrim == 0, "R3", "cm routing", {routeARef, cmTrim}, 0);
          cmSteps = 1;
        end else if (routeAB && cmTrim != prevC) begin
          check(cmTrim == prevC + 1'b1, "R3", "cm code step", cmTrim, prevC + 1);
          check(int'(gainTrim) == expGain, "R3", "gain code held", gainTrim, expGain);
          cmSteps++;
        end
        if (calDone && !prevDone) begin
          check(cmSteps == 16, "R3", "cm codes visited", cmSteps, 16);
          if (expQ.size() == 0) begin
            check(1'b0, "R1", "unexpected completion", 1, 0);
          end else begin
            item = expQ.pop_front();
            check(int'(gainTrim) == item.gain, "R6", "chosen gain code", gainTrim, item.gain);
            check(int'(cmTrim) == item.cm, "R7", "chosen cm code", cmTrim, item.cm);
            check(calPass == item.pass, "R9", "pass flag", calPass, item.pass);
          end
          check(!routeStim && !routeARef && !routeAB, "R8", "routes open",
                {routeStim, routeARef, routeAB}, 0);
        end
        prevARef = routeARef; prevAB = routeAB; prevDone = calDone;
        prevG = gainTrim; prevC = cmTrim;
      end
    end
  end

  // driver: computes the expected outcome, pushes it, runs one calibration
  task automatic runCase(input int spp, input int settle, input int pCm, input bit gaps,
                         input longint target, input longint gLim, input longint cLim,
                         output bit hung);
    longint w, e, err, bestErr, bestE;
    int bestG, bestC, waitCyc;
    expItem_t item;
    logic [CODE_W-1:0] gDone, cDone;
    bit pDone;
    hung = 1'b0;
    cfgSettle = settle; cfgPcm = pCm; cfgGaps = gaps;
    w = longint'(PERIODS) * ((spp == 0) ? 1 : spp);
    bestErr = 0; bestE = 0; bestG = 0; bestC = 0;
    for (int c = 0; c < 16; c++) begin
      e = w * gAmp(c) * gAmp(c);
      err = (e >= target) ? e - target : target - e;
      if (c == 0 || err < bestErr) begin bestErr = err; bestG = c; end
    end
    for (int c = 0; c < 16; c++) begin
      e = w * cAmp(c) * cAmp(c);
      if (c == 0 || e < bestE) begin bestE = e; bestC = c; end
    end
    item.gain = bestG; item.cm = bestC; item.pass = (bestErr <= gLim) && (bestE <= cLim);
    @(negedge clk);
    rstN = 1'b0;
    samplesPerPeriod = SPP_W'(spp);
    settleCount = SETTLE_W'(settle);
    targetEnergy = ACC_W'(target);
    gainErrLimit = ACC_W'(gLim);
    cmEnergyLimit = ACC_W'(cLim);
    expQ.delete();
    expQ.push_back(item);
    repeat (3) @(negedge clk);
    check(!calDone && !calPass, "R10", "flags in reset", {calDone, calPass}, 0);
    check(!routeStim && !routeARef && !routeAB && gainTrim == 0 && cmTrim == 0,
          "R10", "routes and codes in reset", {routeStim, routeARef, routeAB, gainTrim, cmTrim}, 0);
    rstN = 1'b1;
    waitCyc = 0;
    while (!calDone && waitCyc < CASE_LIMIT) begin
      @(negedge clk);
      waitCyc++;
    end
    if (!calDone) begin
      check(1'b0, "R1", "watchdog: calibration never finished", waitCyc, CASE_LIMIT);
      hung = 1'b1;
      return;
    end
    gDone = gainTrim; cDone = cmTrim; pDone = calPass;
    repeat (200) @(negedge clk);
    check(calDone, "R1", "done stays high", calDone, 1);
    check(gainTrim == gDone && cmTrim == cDone && calPass == pDone && !routeStim,
          "R8", "no restart, outputs frozen", {gainTrim, cmTrim}, {gDone, cDone});
  endtask

  initial begin : mainSeq
    bit hung;
    samplesPerPeriod = '0; settleCount = '0;
    targetEnergy = '0; gainErrLimit = '0; cmEnergyLimit = '0;
    hung = 1'b0;
    // exact gain hit at code 6, cm minimum at 9, both limits met with equality
    runCase(2, 3, 18, 1'b0, 64'd2560000, 64'd0, 64'd2500, hung);
    // ties in both phases (gain 4/5, cm 6/7); cm limit one short
    if (!hung) runCase(1, 0, 13, 1'b1, 64'd1052500, 64'd72500, 64'd11249, hung);
    // zero target picks code 0; gain limit one short; cm minimum at 15
    if (!hung) runCase(3, 5, 30, 1'b1, 64'd0, 64'd1499999, 64'd1000000000, hung);
    // period length 0 treated as 1; huge target picks 15; cm minimum at 0
    if (!hung) runCase(0, 2, 0, 1'b0, 64'd1000000000, 64'd1000000000, 64'd1000000000, hung);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule